// File: doc/BRIEF.md
# CAN Error Flag and Code Capture

This block sits beside the protocol engine of a CAN controller and keeps the error reporting state that software sees. Eight event lines latch into sticky flags. Each line is a single-cycle pulse, and the flags cover bus lock, an overload frame sent, receive overrun, bus-off recovery, bus-off entry, error passive, error warning and bus error. Seven error-type lines record what kind of bus error was seen in a separate error-code byte.

The top bit of the error-code byte selects how new error types are recorded. With the bit set, new types are ORed into the bits already held (accumulate mode). With the bit clear, each new report replaces the type bits (latest mode).

Software writes one byte at a time and picks the target register with a select field. The flag bits and the error-type bits are cleared by writing 0 to them, and writing 1 leaves them alone. An enable byte with the same bit layout as the flags gates them into a single error interrupt output.

Top module: `can_err_report`

## Requirements
- R1: After reset the flag, enable and error-code registers read 0x00, and the interrupt output is low.
- R2: A pulse on flag event line n sets flag bit n on the next clock edge. The bit then stays set until software clears it. Bit layout: 7 bus lock, 6 overload sent, 5 receive overrun, 4 bus-off recovery, 3 bus-off entry, 2 error passive, 1 error warning, 0 bus error.
- R3: A write with select 0 (flags) clears every flag bit written as 0 and leaves every bit written as 1 unchanged.
- R4: If an event and a software clear reach the same bit in the same cycle, the event wins and the bit ends up set. This holds for flag bits and for error-type bits.
- R5: A write with select 1 stores the byte in the enable register, which uses the same bit layout as the flags.
- R6: While error-code bit 7 is 1 (accumulate mode), a report on error-type lines ORs the reported bits into bits 6..0. Bit layout: 6 ACK delimiter, 5 bit error dominant, 4 bit error recessive, 3 CRC, 2 ACK, 1 form, 0 stuff.
- R7: While error-code bit 7 is 0 (latest mode), a report on error-type lines sets bits 6..0 to exactly the reported bits and clears all the others.
- R8: A write with select 2 (error code) clears each of bits 6..0 written as 0 and keeps each written as 1. Bit 7, the mode bit, takes the written value directly.
- R9: The interrupt output is high exactly when at least one flag bit and its enable bit are both 1. It follows the register contents in the same cycle.
- R10: A write with select 3 changes no register. A write to one register leaves the other two unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flag_evt_i | input | 8 | Single-cycle error event pulses, one per flag bit |
| code_evt_i | input | 7 | Single-cycle error-type pulses, one per error-code bit 6..0 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 flags, 1 enable, 2 error code, 3 none |
| wr_data_i | input | 8 | Write data byte |
| flag_o | output | 8 | Flag register |
| enable_o | output | 8 | Interrupt enable register |
| code_o | output | 8 | Error-code register, with the mode in bit 7 |
| err_irq_o | output | 1 | Combined error interrupt status |

## Verification
The assertions assume that every event input is a pulse that is sampled on a clock edge while reset is released. They also assume that a write strobe lasts exactly one cycle and that its select and data are stable around that edge.

The stimulus changes every input on the falling edge and holds each strobe for one cycle. It lets the internal reset release settle before the first operation. It includes the collisions of an event with a clear on the same bit, because the ordering rule in R4 is only exercised under those cases.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int unsigned FLAG_W = 8;
  localparam int unsigned CODE_W = 7;

  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_EN   = 2'd1,
    SEL_CODE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/can_err_rst_sync.sv
module can_err_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/can_err_sticky.sv
// Sticky flag bits: an event sets a bit, a write of 0 clears it, and the event wins.
module can_err_sticky #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;
  logic         upd;

  assign upd = wr_i | (|set_i);

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      q_d[b] = q_q[b];
      if (wr_i && !wr_data_i[b]) q_d[b] = 1'b0;
      if (set_i[b])              q_d[b] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q_q[b] <= 1'b0;
      else if (upd) q_q[b] <= q_d[b];
    end

    p_event_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[b] |=> q_o[b]);
    p_write_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !wr_data_i[b] && !set_i[b]) |=> !q_o[b]);
  end

  assign q_o = q_q;

  p_hold_when_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !(|set_i)) |=> $stable(q_o));
endmodule

// File: rtl/can_err_code.sv
// Error-code byte: bits CW-1..0 are the error types, bit CW is the display mode.
module can_err_code #(
  parameter int unsigned CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] evt_i,
  input  logic          wr_i,
  input  logic [CW:0]   wr_data_i,
  output logic [CW:0]   q_o
);
  logic [CW-1:0] type_q, type_d, keep_mask;
  logic          accum_q, accum_d;
  logic          any_evt, upd;

  assign any_evt = |evt_i;
  assign upd     = wr_i | any_evt;

  always_comb begin
    keep_mask = wr_i ? wr_data_i[CW-1:0] : '1;
    accum_d   = wr_i ? wr_data_i[CW] : accum_q;
    if (!any_evt)     type_d = type_q & keep_mask;
    else if (accum_q) type_d = (type_q & keep_mask) | evt_i;
    else              type_d = evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q  <= '0;
      accum_q <= 1'b0;
    end else if (upd) begin
      type_q  <= type_d;
      accum_q <= accum_d;
    end
  end

  assign q_o = {accum_q, type_q};

  p_accum_keeps_new_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o[CW] && any_evt) |=> ((q_o[CW-1:0] & $past(evt_i)) == $past(evt_i)));
  p_accum_keeps_old_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o[CW] && any_evt && !wr_i) |=>
      ((q_o[CW-1:0] & $past(q_o[CW-1:0])) == $past(q_o[CW-1:0])));
  p_latest_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_o[CW] && any_evt) |=> (q_o[CW-1:0] == $past(evt_i)));
  p_write_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !any_evt) |=> ((q_o[CW-1:0] & ~$past(wr_data_i[CW-1:0])) == '0));
  p_mode_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (q_o[CW] == $past(wr_data_i[CW])));
endmodule

// File: rtl/can_err_irq.sv
module can_err_irq #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] flag_i,
  input  logic [W-1:0] en_i,
  output logic         irq_o
);
  logic [W-1:0] hit;

  for (genvar b = 0; b < W; b++) begin : g_gate
    assign hit[b] = flag_i[b] & en_i[b];
  end

  assign irq_o = |hit;
endmodule

// File: rtl/can_err_report.sv
module can_err_report
  import can_err_pkg::*;
#(
  parameter int unsigned N_FLAG = FLAG_W,
  parameter int unsigned N_CODE = CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_FLAG-1:0] flag_evt_i,
  input  logic [N_CODE-1:0] code_evt_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [N_FLAG-1:0] wr_data_i,
  output logic [N_FLAG-1:0] flag_o,
  output logic [N_FLAG-1:0] enable_o,
  output logic [N_FLAG-1:0] code_o,
  output logic              err_irq_o
);
  localparam int unsigned CODE_BYTE = N_CODE + 1;

  logic          rst_n;
  reg_sel_e      sel;
  logic          wr_flag, wr_en_reg, wr_code;
  logic [N_FLAG-1:0] en_q, en_d;
  logic [CODE_BYTE-1:0] code_q;

  assign sel       = reg_sel_e'(wr_sel_i);
  assign wr_flag   = wr_en_i && (sel == SEL_FLAG);
  assign wr_en_reg = wr_en_i && (sel == SEL_EN);
  assign wr_code   = wr_en_i && (sel == SEL_CODE);

  can_err_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  can_err_sticky #(.W(N_FLAG)) i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .set_i     (flag_evt_i),
    .wr_i      (wr_flag),
    .wr_data_i (wr_data_i),
    .q_o       (flag_o)
  );

  can_err_code #(.CW(N_CODE)) i_code (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .evt_i     (code_evt_i),
    .wr_i      (wr_code),
    .wr_data_i (wr_data_i[CODE_BYTE-1:0]),
    .q_o       (code_q)
  );

  always_comb begin
    en_d = en_q;
    if (wr_en_reg) en_d = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (wr_en_reg) en_q <= en_d;
  end

  assign enable_o = en_q;

  if (CODE_BYTE < N_FLAG) begin : g_code_pad
    assign code_o = {{(N_FLAG-CODE_BYTE){1'b0}}, code_q};
  end else begin : g_code_full
    assign code_o = code_q[N_FLAG-1:0];
  end

  can_err_irq #(.W(N_FLAG)) i_irq (
    .flag_i (flag_o),
    .en_i   (en_q),
    .irq_o  (err_irq_o)
  );

  p_enable_store_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en_reg |=> (enable_o == $past(wr_data_i)));
  p_enable_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_en_reg |=> $stable(enable_o));
  p_no_target_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && sel == SEL_NONE && !(|flag_evt_i) && !(|code_evt_i)) |=>
      ($stable(flag_o) && $stable(code_o)));
  p_zero_enable_mutes_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_reg && wr_data_i == '0) |=> !err_irq_o);
  p_flag_write_spares_code_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_flag && !(|code_evt_i)) |=> $stable(code_o));
endmodule

// File: tb/test_can_err_report.sv
`timescale 1ns/1ps
module test_can_err_report;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] flag_evt;
  logic [6:0] code_evt;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic [7:0] flag_o, enable_o, code_o;
  logic       irq_o;

  typedef struct {
    logic [7:0] f;
    logic [7:0] e;
    logic [7:0] c;
    logic       irq;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;
  logic [7:0] mf = 8'h00, me = 8'h00, mc = 8'h00;

  always #2.5 clk = ~clk;

  can_err_report i_can_err_report (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .flag_evt_i (flag_evt),
    .code_evt_i (code_evt),
    .wr_en_i    (wr_en),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data),
    .flag_o     (flag_o),
    .enable_o   (enable_o),
    .code_o     (code_o),
    .err_irq_o  (irq_o)
  );

  task automatic compare(input exp_t x);
    n_run++;
    if (flag_o !== x.f || enable_o !== x.e || code_o !== x.c || irq_o !== x.irq) begin
      n_fail++;
      $display("FAIL %s: got flag=%h en=%h code=%h irq=%b, expected flag=%h en=%h code=%h irq=%b",
               x.req, flag_o, enable_o, code_o, irq_o, x.f, x.e, x.c, x.irq);
    end
  endtask

  // Monitor: one result per clock, sampled after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  // Driver: one operation per cycle; expected state from the requirements.
  task automatic step(input logic [7:0] fe, input logic [6:0] ce, input logic w,
                      input logic [1:0] s, input logic [7:0] d, input string req);
    logic [6:0] keep;
    logic [6:0] typ;
    exp_t x;
    @(negedge clk);
    flag_evt = fe; code_evt = ce; wr_en = w; wr_sel = s; wr_data = d;
    mf   = (mf & ((w && s == 2'd0) ? d : 8'hFF)) | fe;
    me   = (w && s == 2'd1) ? d : me;
    keep = (w && s == 2'd2) ? d[6:0] : 7'h7F;
    if (ce == 7'h00)  typ = mc[6:0] & keep;
    else if (mc[7])   typ = (mc[6:0] & keep) | ce;
    else              typ = ce;
    mc = {((w && s == 2'd2) ? d[7] : mc[7]), typ};
    x.f = mf; x.e = me; x.c = mc; x.irq = |(mf & me); x.req = req;
    exp_q.push_back(x);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #500000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got no completion, expected completion");
    finish_run();
  end

  initial begin
    exp_t r;
    rst_n = 1'b0; flag_evt = '0; code_evt = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    r.f = 8'h00; r.e = 8'h00; r.c = 8'h00; r.irq = 1'b0; r.req = "R1";
    compare(r);

    step(8'h05, 7'h00, 0, 2'd0, 8'h00, "R2");   // bus error + error passive
    step(8'h00, 7'h00, 0, 2'd0, 8'h00, "R2");   // flags stay
    step(8'h00, 7'h00, 1, 2'd1, 8'h04, "R5");   // enable bit 2 -> irq
    step(8'h00, 7'h00, 1, 2'd1, 8'h02, "R9");   // flag without enable -> low
    step(8'h00, 7'h00, 1, 2'd0, 8'hFE, "R3");   // clear bit 0 only
    step(8'h04, 7'h00, 1, 2'd0, 8'h00, "R4");   // clear-all with event on bit 2
    step(8'h00, 7'h00, 1, 2'd3, 8'h00, "R10");  // no target
    step(8'h02, 7'h00, 0, 2'd0, 8'h00, "R9");   // enabled flag -> irq
    step(8'h00, 7'h09, 0, 2'd0, 8'h00, "R7");   // latest mode: CRC + stuff
    step(8'h00, 7'h10, 0, 2'd0, 8'h00, "R7");   // replaced by recessive bit error
    step(8'h00, 7'h00, 1, 2'd2, 8'hFF, "R8");   // mode to accumulate, keep types
    step(8'h00, 7'h03, 0, 2'd0, 8'h00, "R6");   // form + stuff added
    step(8'h00, 7'h40, 0, 2'd0, 8'h00, "R6");   // ACK delimiter added
    step(8'h00, 7'h00, 1, 2'd2, 8'hFD, "R8");   // clear form bit only
    step(8'h00, 7'h02, 1, 2'd2, 8'hFD, "R4");   // event beats clear on same type bit
    step(8'h00, 7'h00, 1, 2'd2, 8'h7F, "R8");   // mode back to latest
    step(8'h00, 7'h04, 0, 2'd0, 8'h00, "R7");   // ACK error replaces all
    step(8'h00, 7'h08, 1, 2'd2, 8'h00, "R7");   // latest mode, event with clear
    step(8'h00, 7'h00, 1, 2'd0, 8'hFF, "R10");  // flag write keeps all, others untouched
    step(8'h00, 7'h00, 1, 2'd1, 8'h00, "R9");   // all enables off -> low
    step(8'h00, 7'h00, 0, 2'd0, 8'h00, "R9");

    @(negedge clk);
    flag_evt = '0; code_evt = '0; wr_en = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    finish_run();
  end
endmodule